// File: doc/BRIEF.md
# Frame Length Status FIFO

This block keeps a small queue of the byte counts of received infrared frames. When the frame receiver finishes a frame it presents the frame's 12-bit length (address field through CRC bytes, inclusive) with a one-cycle push strobe. The host sees the oldest queued length through two byte-wide length registers: one holds the low eight bits and the other holds the upper four bits. Reading these registers does not consume the entry, so software may read them in any order and as often as it likes.

An entry is removed only when the host reads a separate line-status register. That register also reports whether data is waiting, whether the queue is full, and whether any length has been lost. Writing a one to bit 7 of the control register flushes the queue and clears the loss flag. This flush bit reads back as one for a single cycle and then clears itself.

Occupancy is tracked by a four-state machine. Its states are:
- `ST_EMPTY`: no entries.
- `ST_PARTIAL`: between one and DEPTH-1 entries.
- `ST_FULL`: DEPTH entries.
- `ST_FLUSH`: the single cycle after a flush request.

Its transitions are:
- From any state, a flush request leads to `ST_FLUSH`.
- `ST_FLUSH` always leads to `ST_EMPTY`.
- From `ST_EMPTY`, an accepted push leads to `ST_PARTIAL`.
- From `ST_PARTIAL`, an accepted push with no pop leads to `ST_FULL` when the count was DEPTH-1.
- From `ST_PARTIAL`, a pop with no push leads to `ST_EMPTY` when the count was 1.
- From `ST_FULL`, a pop leads to `ST_PARTIAL`.

Top module: `fls_status_fifo`

## Requirements
- R1: After reset the queue is empty: `fifo_empty`=1, `fifo_full`=0 and `fifo_overflow`=0. The control register (select 3) reads 0x00.
- R2: Lengths are returned oldest first. With select 0 (length low), `bus_rdata` equals bits 7..0 of the oldest entry. With select 1 (length high), bits 3..0 of `bus_rdata` hold bits 11..8 of that entry and bits 7..4 read 0.
- R3: Reading select 0 or select 1 changes neither the oldest entry nor the occupancy.
- R4: A read strobe with select 2 (line status) returns a status byte in the same cycle. Bit 0 is data-ready, bit 1 is overflow, bit 2 is full, and the other bits are 0. When the queue is not empty, the strobe removes the oldest entry at the clock edge.
- R5: A line-status read on an empty queue returns 0x00 and moves no pointer. A later push is then the entry returned by select 0.
- R6: The queue holds 8 entries. `fifo_full` rises on the eighth push without a pop and falls after the next pop.
- R7: A push while the queue is full is discarded and sets `fifo_overflow`. This also applies when a pop happens in the same cycle. The flag stays set through later pops until a flush.
- R8: A write with select 3 and bit 7 set empties the queue and clears `fifo_overflow` at that clock edge. Bit 7 of the control register then reads 1 for exactly one cycle and 0 afterwards. A write with bit 7 clear changes nothing.
- R9: A push in the cycle that follows a flush request is discarded without setting `fifo_overflow`.
- R10: When the queue is not full, a push and a line-status pop may happen in the same cycle. If the queue is not empty, both take effect and the order is kept. If it is empty, the push is stored and the pop is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_push | input | 1 | End-of-frame strobe from the receiver |
| rx_len | input | 12 | Frame byte count presented with the strobe |
| bus_rd | input | 1 | Host read strobe |
| bus_wr | input | 1 | Host write strobe |
| bus_sel | input | 2 | Register select: 0 length low, 1 length high, 2 line status, 3 control |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Host read data for the selected register (combinational) |
| fifo_empty | output | 1 | Queue holds no entry |
| fifo_full | output | 1 | Queue holds DEPTH entries |
| fifo_overflow | output | 1 | Sticky: a length was discarded because the queue was full |

## Verification
The bench pushes distinct lengths whose low and high parts differ, so that a swapped byte lane or a misplaced nibble shows up. Long runs of repeated length reads between pops separate a peek from a consuming read. Filling past the depth, with and without a pop in the same cycle, tells a correct drop apart from an overwrite or a lost pop. Push and pop in the same cycle are tried on an empty queue and on a non-empty one. A push in the cycle after a flush checks that the flush window is applied correctly. A line-status read on an empty queue followed by a push exposes any read-pointer drift.

// File: rtl/fls_pkg.sv
package fls_pkg;

    typedef enum logic [1:0] {
        SEL_LEN_LO = 2'd0,
        SEL_LEN_HI = 2'd1,
        SEL_LSR    = 2'd2,
        SEL_CTRL   = 2'd3
    } fls_sel_e;

    typedef enum logic [1:0] {
        ST_EMPTY   = 2'd0,
        ST_PARTIAL = 2'd1,
        ST_FULL    = 2'd2,
        ST_FLUSH   = 2'd3
    } fls_state_e;

    localparam int CTRL_FLUSH_BIT = 7;
    localparam int LSR_READY_BIT  = 0;
    localparam int LSR_OVF_BIT    = 1;
    localparam int LSR_FULL_BIT   = 2;

endpackage

// File: rtl/fls_ctrl.sv
module fls_ctrl
    import fls_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push_req,
    input  logic       pop_req,
    input  logic       flush_req,
    input  logic [CW-1:0] cnt,
    output fls_state_e state,
    output logic       push_ok,
    output logic       pop_ok,
    output logic       drop,
    output logic       clr,
    output logic       is_empty,
    output logic       is_full,
    output logic       flushing
);

    fls_state_e state_nxt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_EMPTY;
        else        state <= state_nxt;
    end

    // next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_EMPTY: begin
                if (flush_req)    state_nxt = ST_FLUSH;
                else if (push_ok) state_nxt = (DEPTH == 1) ? ST_FULL : ST_PARTIAL;
            end
            ST_PARTIAL: begin
                if (flush_req)
                    state_nxt = ST_FLUSH;
                else if (push_ok && !pop_ok && cnt == CW'(DEPTH - 1))
                    state_nxt = ST_FULL;
                else if (pop_ok && !push_ok && cnt == CW'(1))
                    state_nxt = ST_EMPTY;
            end
            ST_FULL: begin
                if (flush_req)   state_nxt = ST_FLUSH;
                else if (pop_ok) state_nxt = (DEPTH == 1) ? ST_EMPTY : ST_PARTIAL;
            end
            ST_FLUSH: begin
                if (flush_req) state_nxt = ST_FLUSH;
                else           state_nxt = ST_EMPTY;
            end
            default: state_nxt = ST_EMPTY;
        endcase
    end

    // output logic
    always_comb begin
        push_ok  = 1'b0;
        pop_ok   = 1'b0;
        drop     = 1'b0;
        clr      = flush_req;
        is_empty = 1'b0;
        is_full  = 1'b0;
        flushing = 1'b0;
        unique case (state)
            ST_EMPTY: begin
                is_empty = 1'b1;
                push_ok  = push_req && !flush_req;
            end
            ST_PARTIAL: begin
                push_ok = push_req && !flush_req;
                pop_ok  = pop_req && !flush_req;
            end
            ST_FULL: begin
                is_full = 1'b1;
                pop_ok  = pop_req && !flush_req;
                drop    = push_req && !flush_req;
            end
            ST_FLUSH: begin
                is_empty = 1'b1;
                flushing = 1'b1;
            end
            default: is_empty = 1'b1;
        endcase
    end

    assert_full_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FULL) |-> (cnt == CW'(DEPTH)));

    assert_empty_count_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EMPTY || state == ST_FLUSH) |-> (cnt == '0));

    assert_lsr_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EMPTY && pop_req && !push_req && !flush_req) |=> (state == ST_EMPTY));

    assert_flush_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FLUSH && !flush_req) |=> (state == ST_EMPTY));

    assert_flush_enter_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |=> (state == ST_FLUSH));

endmodule

// File: rtl/fls_store.sv
module fls_store #(
    parameter int DEPTH = 8,
    parameter int LEN_W = 12,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [LEN_W-1:0] wr_data,
    input  logic             rd_en,
    input  logic             clr,
    output logic [LEN_W-1:0] head,
    output logic [CW-1:0]    cnt
);

    logic [LEN_W-1:0] mem [DEPTH];
    logic [PW-1:0]    wptr;
    logic [PW-1:0]    rptr;

    function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (wr_en) mem[wptr] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
        end else if (clr) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
        end else begin
            if (wr_en) wptr <= ptr_inc(wptr);
            if (rd_en) rptr <= ptr_inc(rptr);
            unique case ({wr_en, rd_en})
                2'b10:   cnt <= cnt + CW'(1);
                2'b01:   cnt <= cnt - CW'(1);
                default: cnt <= cnt;
            endcase
        end
    end

    assign head = mem[rptr];

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));

    assert_peek_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en && !clr) |=> $stable(rptr));

    assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0) |-> !rd_en);

endmodule

// File: rtl/fls_regs.sv
module fls_regs
    import fls_pkg::*;
#(
    parameter int LEN_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  fls_sel_e         sel,
    input  logic [LEN_W-1:0] head,
    input  logic             is_empty,
    input  logic             is_full,
    input  logic             flushing,
    input  logic             drop,
    input  logic             clr,
    output logic [7:0]       rdata,
    output logic             ovf
);

    localparam int HI_PAD = 16 - LEN_W;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    ovf <= 1'b0;
        else if (clr)  ovf <= 1'b0;
        else if (drop) ovf <= 1'b1;
    end

    always_comb begin
        rdata = '0;
        unique case (sel)
            SEL_LEN_LO: rdata = head[7:0];
            SEL_LEN_HI: rdata = {{HI_PAD{1'b0}}, head[LEN_W-1:8]};
            SEL_LSR: begin
                rdata[LSR_READY_BIT] = !is_empty;
                rdata[LSR_OVF_BIT]   = ovf;
                rdata[LSR_FULL_BIT]  = is_full;
            end
            SEL_CTRL: rdata[CTRL_FLUSH_BIT] = flushing;
            default: rdata = '0;
        endcase
    end

    assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !clr) |=> ovf);

    assert_ovf_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (drop && !clr) |=> ovf);

    assert_ovf_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !ovf);

endmodule

// File: rtl/fls_status_fifo.sv
module fls_status_fifo
    import fls_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int LEN_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_push,
    input  logic [LEN_W-1:0] rx_len,
    input  logic             bus_rd,
    input  logic             bus_wr,
    input  logic [1:0]       bus_sel,
    input  logic [7:0]       bus_wdata,
    output logic [7:0]       bus_rdata,
    output logic             fifo_empty,
    output logic             fifo_full,
    output logic             fifo_overflow
);

    localparam int CW = $clog2(DEPTH + 1);

    fls_sel_e         sel;
    fls_state_e       state;
    logic             pop_req, flush_req;
    logic             push_ok, pop_ok, drop, clr, flushing;
    logic [CW-1:0]    cnt;
    logic [LEN_W-1:0] head;

    assign sel       = fls_sel_e'(bus_sel);
    assign pop_req   = bus_rd && (sel == SEL_LSR);
    assign flush_req = bus_wr && (sel == SEL_CTRL) && bus_wdata[CTRL_FLUSH_BIT];

    fls_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_req (rx_push),
        .pop_req  (pop_req),
        .flush_req(flush_req),
        .cnt      (cnt),
        .state    (state),
        .push_ok  (push_ok),
        .pop_ok   (pop_ok),
        .drop     (drop),
        .clr      (clr),
        .is_empty (fifo_empty),
        .is_full  (fifo_full),
        .flushing (flushing)
    );

    fls_store #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (push_ok),
        .wr_data(rx_len),
        .rd_en  (pop_ok),
        .clr    (clr),
        .head   (head),
        .cnt    (cnt)
    );

    fls_regs #(.LEN_W(LEN_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (sel),
        .head    (head),
        .is_empty(fifo_empty),
        .is_full (fifo_full),
        .flushing(flushing),
        .drop    (drop),
        .clr     (clr),
        .rdata   (bus_rdata),
        .ovf     (fifo_overflow)
    );

    assert_flags_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_empty && fifo_full));

    assert_full_no_store_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FULL && !bus_rd) |=> fifo_full || flushing);

endmodule

// File: tb/fls_status_fifo_test.sv
module fls_status_fifo_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_push = 1'b0;
    logic [11:0] rx_len = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_sel = 2'd0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        fifo_empty, fifo_full, fifo_overflow;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    fls_status_fifo uut (
        .clk(clk), .rst_n(rst_n), .rx_push(rx_push), .rx_len(rx_len),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_sel(bus_sel),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .fifo_empty(fifo_empty), .fifo_full(fifo_full), .fifo_overflow(fifo_overflow)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // one clock cycle of stimulus, starting and ending at a falling edge
    task automatic cyc(input logic p, input logic [11:0] len, input logic rd,
                       input logic wr, input logic [1:0] sel, input logic [7:0] wd,
                       output logic [7:0] rdat);
        rx_push = p; rx_len = len; bus_rd = rd; bus_wr = wr;
        bus_sel = sel; bus_wdata = wd;
        #1 rdat = bus_rdata;
        @(negedge clk);
        rx_push = 1'b0; bus_rd = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic push(input logic [11:0] len);
        logic [7:0] d;
        cyc(1'b1, len, 1'b0, 1'b0, 2'd0, 8'h00, d);
    endtask

    task automatic pop(output logic [7:0] lsr);
        cyc(1'b0, 12'h0, 1'b1, 1'b0, 2'd2, 8'h00, lsr);
    endtask

    task automatic peek(input logic [1:0] sel, output logic [7:0] d);
        bus_sel = sel;
        #1 d = bus_rdata;
    endtask

    task automatic t_reset;
        logic [7:0] d;
        check("R1 empty", int'(fifo_empty), 1);
        check("R1 full", int'(fifo_full), 0);
        check("R1 overflow", int'(fifo_overflow), 0);
        peek(2'd3, d);
        check("R1 ctrl", int'(d), 8'h00);
    endtask

    task automatic t_order;
        logic [7:0] d;
        push(12'hABC); push(12'h123); push(12'h0FF);
        peek(2'd0, d); check("R2 lo #1", int'(d), 8'hBC);
        peek(2'd1, d); check("R2 hi #1", int'(d), 8'h0A);
        pop(d);        check("R4 lsr ready", int'(d), 8'h01);
        peek(2'd0, d); check("R2 lo #2", int'(d), 8'h23);
        peek(2'd1, d); check("R2 hi #2", int'(d), 8'h01);
        pop(d);
        peek(2'd0, d); check("R2 lo #3", int'(d), 8'hFF);
        peek(2'd1, d); check("R2 hi #3", int'(d), 8'h00);
        pop(d);
        check("R4 empty after pops", int'(fifo_empty), 1);
    endtask

    task automatic t_peek;
        logic [7:0] d;
        push(12'h5A7);
        for (int i = 0; i < 5; i++) cyc(1'b0, 12'h0, 1'b1, 1'b0, 2'd0, 8'h00, d);
        for (int i = 0; i < 3; i++) cyc(1'b0, 12'h0, 1'b1, 1'b0, 2'd1, 8'h00, d);
        peek(2'd0, d); check("R3 head after peeks", int'(d), 8'hA7);
        check("R3 not empty", int'(fifo_empty), 0);
        pop(d);
        check("R3 single entry popped", int'(fifo_empty), 1);
    endtask

    task automatic t_lsr_empty;
        logic [7:0] d;
        pop(d); check("R5 lsr on empty", int'(d), 8'h00);
        pop(d);
        push(12'h311);
        peek(2'd0, d); check("R5 no pointer drift", int'(d), 8'h11);
        pop(d);
        check("R5 drained", int'(fifo_empty), 1);
    endtask

    task automatic t_full;
        logic [7:0] d;
        for (int i = 1; i <= 7; i++) push(12'(12'h100 + i));
        check("R6 not full at 7", int'(fifo_full), 0);
        push(12'h108);
        check("R6 full at 8", int'(fifo_full), 1);
        peek(2'd2, d); check("R4 lsr full", int'(d), 8'h05);
        push(12'hEEE);
        check("R7 overflow set", int'(fifo_overflow), 1);
        peek(2'd2, d); check("R4 lsr ovf", int'(d), 8'h07);
        // push and pop together while full: push dropped
        cyc(1'b1, 12'hDDD, 1'b1, 1'b0, 2'd2, 8'h00, d);
        check("R6 full falls", int'(fifo_full), 0);
        for (int i = 2; i <= 8; i++) begin
            peek(2'd0, d); check("R7 kept order", int'(d), (i & 8'hFF) | 8'h00);
            pop(d);
        end
        check("R7 dropped never stored", int'(fifo_empty), 1);
        check("R7 sticky", int'(fifo_overflow), 1);
    endtask

    task automatic t_flush;
        logic [7:0] d;
        push(12'h222); push(12'h333);
        cyc(1'b0, 12'h0, 1'b0, 1'b1, 2'd3, 8'h80, d);
        peek(2'd3, d); check("R8 self-clear bit set", int'(d), 8'h80);
        check("R8 emptied", int'(fifo_empty), 1);
        check("R8 ovf cleared", int'(fifo_overflow), 0);
        cyc(1'b1, 12'h777, 1'b0, 1'b0, 2'd3, 8'h00, d);
        peek(2'd3, d); check("R8 bit cleared", int'(d), 8'h00);
        check("R9 push in flush dropped", int'(fifo_empty), 1);
        check("R9 no overflow", int'(fifo_overflow), 0);
        push(12'h444);
        cyc(1'b0, 12'h0, 1'b0, 1'b1, 2'd3, 8'h7F, d);
        peek(2'd0, d); check("R8 write without bit7 ignored", int'(d), 8'h44);
        check("R8 still holds", int'(fifo_empty), 0);
        pop(d);
    endtask

    task automatic t_simul;
        logic [7:0] d;
        cyc(1'b1, 12'h321, 1'b1, 1'b0, 2'd2, 8'h00, d);
        check("R10 lsr before push", int'(d), 8'h00);
        peek(2'd0, d); check("R10 push kept on empty", int'(d), 8'h21);
        cyc(1'b1, 12'h654, 1'b1, 1'b0, 2'd2, 8'h00, d);
        peek(2'd0, d); check("R10 both act", int'(d), 8'h54);
        peek(2'd1, d); check("R10 hi", int'(d), 8'h06);
        pop(d);
        check("R10 one entry left", int'(fifo_empty), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_order;
        t_peek;
        t_lsr_empty;
        t_full;
        t_flush;
        t_simul;
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #800000;
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule